// File: doc/BRIEF.md
# PS/2 Host Receiver with Flow Control

This block lets a CPU collect bytes sent by a PS/2 device such as a mouse. Two port pins carry the device clock and data while the receiver is enabled. The block synchronises and filters the device clock. On each falling edge it takes one data bit and assembles an 11-bit frame: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1. It stores each good byte in a two-entry buffer and raises a flag for the CPU.

When both buffer entries hold unread bytes, the block pulls the device clock low so that the device holds off further frames. It lets the clock go as soon as the CPU reads a byte. The CPU reaches the block through a small register port. Address 0 is control/status: bit 0 is the enable, bit 1 is the received flag (write 1 to clear) and bit 2 is the inhibit state, which is read-only. Address 1 is the data register. A read of address 1 returns the oldest unread byte and removes it from the buffer. Read data appears on the cycle after the read strobe.

Top module: `ps2_host_rx`

## Requirements
- R1: After reset the enable and the flag are 0, the clock is not held, a control read returns 0 and a data read returns 0.
- R2: While the enable (control bit 0) is 0, activity on the PS/2 pins stores no byte and sets no flag, and the clock is never held.
- R3: A frame with start 0, data LSB first, odd parity and stop 1 stores its byte, and the flag (control bit 1) reads 1 afterwards.
- R4: A frame whose parity bit makes the count of ones in data plus parity even is discarded.
- R5: A frame whose stop bit is 0 is discarded.
- R6: Data reads return stored bytes oldest first, each exactly once. A data read with nothing stored returns 0.
- R7: From the cycle after both entries are filled, the clock-hold output is 1 (control bit 2 reads 1). A frame that completes while the buffer is full is dropped.
- R8: The cycle after a data read frees an entry, the clock-hold output returns to 0.
- R9: Writing control with bit 1 set clears the flag. Writing bit 1 as 0 leaves the flag unchanged.
- R10: If no falling clock edge arrives for TIMEOUT_CYC cycles in the middle of a frame, the partial frame is abandoned and the next frame decodes correctly.
- R11: A low pulse on the device clock shorter than FILT_LEN system-clock samples is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 1 | 0 = control/status, 1 = data |
| bus_wdata_i | input | 2 | Control write fields: bit 0 enable, bit 1 flag clear |
| bus_rdata_o | output | 8 | Registered read data |
| ps2_clk_i | input | 1 | Device clock pin level |
| ps2_data_i | input | 1 | Device data pin level |
| ps2_clk_hold_o | output | 1 | 1 = drive device clock low (inhibit) |
| rx_flag_o | output | 1 | Received flag |

## Verification
On every cycle the assertions check these properties: the buffer occupancy stays within its depth, the hold follows a full buffer, and the hold stays off while the block is disabled. They also check that the bit counter stays in range, that a timeout returns the counter to idle, and that a store or a flag clear moves the flag the cycle after. The bench scenarios are the only evidence for the decoded values of all 256 bytes and for the oldest-first order. The same holds for rejection of bad parity and bad stop bits, loss of a byte that arrives while the buffer is full, recovery after an abandoned frame, and immunity to short clock glitches.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic {REG_CTRL = 1'b0, REG_DATA = 1'b1} reg_addr_e;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int CTRL_HOLD_BIT = 2;
  localparam int SYNC_STAGES   = 2;
endpackage

// File: rtl/ps2_clk_filter.sv
module ps2_clk_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic fall_o
);
  import ps2_rx_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   level_q;
  logic                   fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      win_q   <= '1;
      level_q <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      fall_q <= 1'b0;
      if (&win_q) begin
        level_q <= 1'b1;
      end else if (~|win_q) begin
        level_q <= 1'b0;
        fall_q  <= level_q;
      end
    end
  end

  assign fall_o = fall_q;

  p_fall_single_r11: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              fall_i,
  input  logic              data_pin_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o
);
  import ps2_rx_pkg::*;

  localparam int LAST  = DATA_W + 2;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

  logic [SYNC_STAGES-1:0] dsync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [TO_W-1:0]        to_q;
  logic [DATA_W-1:0]      sr_q;
  logic                   par_q;
  logic                   valid_q;
  logic [DATA_W-1:0]      byte_q;
  logic                   dbit;

  assign dbit = dsync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) dsync_q <= '1;
    else     dsync_q <= {dsync_q[SYNC_STAGES-2:0], data_pin_i};
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q   <= '0;
      to_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (fall_i) begin
        to_q <= '0;
        if (cnt_q == '0) begin
          if (!dbit) cnt_q <= CNT_W'(1);
        end else if (cnt_q <= CNT_W'(DATA_W)) begin
          sr_q  <= {dbit, sr_q[DATA_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q == CNT_W'(DATA_W + 1)) begin
          par_q <= dbit;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          if (dbit && ((^sr_q) ^ par_q)) begin
            valid_q <= 1'b1;
            byte_q  <= sr_q;
          end
          cnt_q <= '0;
        end
      end else if (cnt_q != '0) begin
        if (to_q == TO_W'(TIMEOUT_CYC - 1)) begin
          cnt_q <= '0;
          to_q  <= '0;
        end else begin
          to_q <= to_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;

  p_cnt_range_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LAST));
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && !fall_i && cnt_q != '0 && to_q == TO_W'(TIMEOUT_CYC - 1)) |=> cnt_q == '0);
  p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0 && !valid_q));
endmodule

// File: rtl/ps2_byte_fifo.sv
module ps2_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));
  p_full_push_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (full_o && !pop_i) |=> full_o);
  p_pop_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty_o && !push_i) |=> !full_o);
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int FILT_LEN    = 3,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_addr_i,
  input  logic [1:0]        bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  output logic              ps2_clk_hold_o,
  output logic              rx_flag_o
);
  import ps2_rx_pkg::*;

  logic              en_q, flag_q, hold_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fall;
  logic              fr_valid;
  logic [DATA_W-1:0] fr_byte;
  logic [DATA_W-1:0] head;
  logic              empty, full;
  logic              store, pop, ctrl_wr;

  ps2_clk_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .pin_i(ps2_clk_i), .fall_o(fall));

  ps2_frame_rx #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst(rst), .en_i(en_q), .fall_i(fall),
    .data_pin_i(ps2_data_i), .valid_o(fr_valid), .byte_o(fr_byte));

  assign store   = fr_valid && !full;
  assign pop     = bus_rd_i && (bus_addr_i == REG_DATA);
  assign ctrl_wr = bus_wr_i && (bus_addr_i == REG_CTRL);

  ps2_byte_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(store), .push_data_i(fr_byte),
    .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
      hold_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata_i[CTRL_EN_BIT];
      if (store)
        flag_q <= 1'b1;
      else if (ctrl_wr && bus_wdata_i[CTRL_FLAG_BIT])
        flag_q <= 1'b0;
      hold_q <= en_q && full;
      if (bus_rd_i) begin
        if (bus_addr_i == REG_DATA) begin
          rdata_q <= empty ? '0 : head;
        end else begin
          rdata_q <= '0;
          rdata_q[CTRL_EN_BIT]   <= en_q;
          rdata_q[CTRL_FLAG_BIT] <= flag_q;
          rdata_q[CTRL_HOLD_BIT] <= hold_q;
        end
      end
    end
  end

  assign bus_rdata_o    = rdata_q;
  assign ps2_clk_hold_o = hold_q;
  assign rx_flag_o      = flag_q;

  p_hold_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q && full) |=> ps2_clk_hold_o);
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    !full |=> !ps2_clk_hold_o);
  p_no_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !ps2_clk_hold_o);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    store |=> rx_flag_o);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata_i[CTRL_FLAG_BIT] && !store) |=> !rx_flag_o);
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_flag_o && !(ctrl_wr && bus_wdata_i[CTRL_FLAG_BIT])) |=> rx_flag_o);
endmodule

// File: tb/ps2_host_rx_tb.sv
module ps2_host_rx_tb;
  localparam int HALF = 10;
  localparam int TO   = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [1:0] bus_wdata = 2'b00;
  logic [7:0] bus_rdata;
  logic       pclk = 1'b1, pdat = 1'b1;
  logic       hold, flag;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ps2_host_rx #(.DATA_W(8), .FIFO_DEPTH(2), .FILT_LEN(3), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ps2_clk_i(pclk), .ps2_data_i(pdat), .ps2_clk_hold_o(hold), .rx_flag_o(flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 11 sends a truncated frame; glitch adds a 1-cycle low pulse in bit 5
  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                      input int nbits, input bit glitch);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); pdat = fr[i];
      if (glitch && i == 5) begin
        idle(4); pclk = 1'b0; idle(1); pclk = 1'b1; idle(HALF - 5);
      end else begin
        idle(HALF);
      end
      pclk = 1'b0; idle(HALF); pclk = 1'b1;
    end
    pdat = 1'b1;
    idle(12);
  endtask

  initial begin
    logic [7:0] v;
    idle(4); rst = 1'b0; idle(2);
    // R1 reset state
    chk("R1 flag", flag, 0);
    chk("R1 hold", hold, 0);
    rd_reg(1'b0, v); chk("R1 ctrl", v, 0);
    rd_reg(1'b1, v); chk("R1 data", v, 0);
    // R2 disabled
    send(8'h5A, 0, 0, 11, 0);
    chk("R2 flag", flag, 0);
    wr_ctrl(2'b01);
    rd_reg(1'b1, v); chk("R2 data", v, 0);
    // R3 sweep over all byte values, R9 clear
    for (int k = 0; k < 256; k++) begin
      send(8'(k), 0, 0, 11, 0);
      chk("R3 flag", flag, 1);
      rd_reg(1'b1, v); chk("R3 data", v, k);
      wr_ctrl(2'b11); chk("R9 clear", flag, 0);
    end
    // R9 write 0 keeps flag
    send(8'h3C, 0, 0, 11, 0);
    wr_ctrl(2'b01); chk("R9 keep", flag, 1);
    rd_reg(1'b1, v); chk("R9 data", v, 8'h3C);
    wr_ctrl(2'b11);
    // R4 / R5 bad frames
    for (int k = 0; k < 256; k += 37) begin
      send(8'(k), 1, 0, 11, 0);
      chk("R4 flag", flag, 0);
      rd_reg(1'b1, v); chk("R4 data", v, 0);
      send(8'(k), 0, 1, 11, 0);
      chk("R5 flag", flag, 0);
      rd_reg(1'b1, v); chk("R5 data", v, 0);
    end
    // R6 / R7 / R8 buffering and flow control
    send(8'h11, 0, 0, 11, 0);
    chk("R7 no hold one", hold, 0);
    send(8'h22, 0, 0, 11, 0);
    chk("R7 hold", hold, 1);
    rd_reg(1'b0, v); chk("R7 ctrl", v, 8'h07);
    send(8'h33, 0, 0, 11, 0);
    rd_reg(1'b1, v); chk("R6 first", v, 8'h11);
    idle(1); chk("R8 release", hold, 0);
    rd_reg(1'b1, v); chk("R6 second", v, 8'h22);
    rd_reg(1'b1, v); chk("R7 dropped", v, 0);
    wr_ctrl(2'b11);
    // R2 disabling releases the hold
    send(8'h44, 0, 0, 11, 0); send(8'h55, 0, 0, 11, 0);
    wr_ctrl(2'b00); idle(1); chk("R2 hold off", hold, 0);
    wr_ctrl(2'b01);
    rd_reg(1'b1, v); chk("R2 kept", v, 8'h44);
    rd_reg(1'b1, v); chk("R2 kept2", v, 8'h55);
    wr_ctrl(2'b11);
    // R10 timeout
    send(8'hFF, 0, 0, 4, 0);
    idle(TO + 50);
    send(8'hA5, 0, 0, 11, 0);
    rd_reg(1'b1, v); chk("R10 data", v, 8'hA5);
    wr_ctrl(2'b11);
    // R11 glitch filter
    send(8'h6B, 0, 0, 11, 1);
    chk("R11 flag", flag, 1);
    rd_reg(1'b1, v); chk("R11 data", v, 8'h6B);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule